// File: doc/BRIEF.md
# Block-Ownership Store Checker

This block sits on the data-RAM port of a small microcontroller core and vets every store instruction before it lands. Data memory is treated as a row of 8-byte blocks. Each block has a 4-bit record in a packed table, the ownership map, which is itself held in data RAM at a configurable base address. When the core's decoder flags a store from any domain other than the trusted one, the block stalls the core and takes over the RAM port. It reads the map byte covering the target block, picks out that block's record, and lets the write through only if the record names the running domain as owner.

Stores that fall in the run-time stack region skip the ownership lookup. They are judged against the stack bound set up for the running domain instead. A refused store never reaches RAM. It raises a one-cycle panic, and the faulting address is latched for software to inspect until it is cleared. Stores from the trusted domain, and RAM writes that are not flagged as store instructions, pass straight through with no added latency.

Top module: `store_guard`

## Requirements
- R1: After reset, with no write request, `stall`, `panic`, `fault_vld` and `ram_we` are all 0.
- R2: A flagged store (`st_instr`=1, `cpu_we`=1) from a domain other than 0 raises `stall` in the cycle it is presented and in the next cycle, then drops it, so the store occupies three cycles. `ram_we` is 0 while `stall` is 1. In the first cycle `ram_addr` equals `map_base + cpu_addr[11:4]`.
- R3: The block number is `cpu_addr[11:3]`. The block's record is bits 3:0 of the map byte when `cpu_addr[3]` is 0 and bits 7:4 when it is 1. Record bits 3:1 hold the owner domain and record bit 0 (the segment-start flag) has no effect on the verdict. Address bits 2:0 also have no effect on the verdict.
- R4: A checked store outside the stack region is written in its third cycle, with `ram_we`=1, `cpu_addr` and `cpu_wdata`, exactly when the owner in its record equals `cur_dom`.
- R5: A checked store with `cpu_addr >= stk_floor` ignores the map. It is written only when `cpu_addr < stk_bound`.
- R6: A refused store leaves RAM unchanged and drives `panic` high for exactly one cycle, the store's third cycle.
- R7: On a refusal while `fault_vld` is 0, `fault_addr` takes the store address and `fault_vld` is set. Later refusals do not change `fault_addr` while `fault_vld` stays set. A `fault_clr` pulse clears `fault_vld`.
- R8: A store while `cur_dom` is 0 (the trusted domain) is not checked. `stall` stays 0 and the write goes to RAM in the same cycle.
- R9: A write with `st_instr`=0 is not checked. `stall` stays 0 and the write goes to RAM in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_instr | input | 1 | Decoder flag: the current write comes from a store instruction |
| cpu_we | input | 1 | Core write enable |
| cpu_addr | input | 12 | Core data address |
| cpu_wdata | input | 8 | Core write data |
| cur_dom | input | 3 | Domain currently executing |
| map_base | input | 12 | RAM address of the ownership map |
| stk_floor | input | 12 | Lowest address of the run-time stack region |
| stk_bound | input | 12 | Stack bound of the running domain (first forbidden address) |
| ram_rdata | input | 8 | RAM read data, one cycle after the address |
| fault_clr | input | 1 | Clears the latched fault |
| stall | output | 1 | Holds the core while a check runs |
| ram_addr | output | 12 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| panic | output | 1 | One-cycle pulse on a refused store |
| fault_vld | output | 1 | A fault address is latched |
| fault_addr | output | 12 | Address of the first refused store |

## Verification
The bench targets the nibble choice between two blocks that share one map byte. A design that swaps the halves lets the neighbour's owner write and refuses the real owner. It also targets addresses exactly at the stack bound and one below it, where an off-by-one comparison either lets a callee reach its caller's frame or blocks a legal push. Back-to-back refusals check that the first fault address is kept rather than overwritten. Trusted and unflagged writes are timed to catch a design that stalls them or drops them. Random stores, with owners and bounds drawn at random, are judged against a reference verdict computed from the bench's own copy of the map.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    SG_IDLE   = 2'd0,
    SG_LOOK   = 2'd1,
    SG_COMMIT = 2'd2
  } sg_state_e;
endpackage

// File: rtl/sg_locate.sv
// Address decode: map byte address, record slot, stack-region tests.
module sg_locate #(
  parameter int AW     = 12,
  parameter int BLK_LG = 3,
  parameter int SEL_W  = 1
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    map_base,
  input  logic [AW-1:0]    stk_floor,
  input  logic [AW-1:0]    stk_bound,
  output logic [AW-1:0]    map_addr,
  output logic [SEL_W-1:0] rec_sel,
  output logic             in_stack,
  output logic             stack_ok
);
  localparam int BW = AW - BLK_LG;

  logic [BW-1:0] blk;

  assign blk      = addr[AW-1:BLK_LG];
  assign rec_sel  = blk[SEL_W-1:0];
  assign map_addr = map_base + AW'(blk >> SEL_W);
  assign in_stack = (addr >= stk_floor);
  assign stack_ok = (addr < stk_bound);
endmodule

// File: rtl/sg_owner_match.sv
// Picks one record out of a map byte and compares its owner field.
module sg_owner_match #(
  parameter int DW    = 8,
  parameter int DOM_W = 3,
  parameter int REC_W = DOM_W + 1,
  parameter int SEL_W = 1
) (
  input  logic [DW-1:0]    rdata,
  input  logic [SEL_W-1:0] rec_sel,
  input  logic [DOM_W-1:0] dom,
  output logic             match
);
  localparam int REC_PER = DW / REC_W;

  logic [REC_W-1:0] recs [REC_PER];
  logic [REC_W-1:0] rec;

  for (genvar g = 0; g < REC_PER; g++) begin : g_rec
    assign recs[g] = rdata[g*REC_W +: REC_W];
  end

  assign rec   = recs[rec_sel];
  assign match = (rec[REC_W-1:1] == dom);
endmodule

// File: rtl/store_guard.sv
module store_guard #(
  parameter int AW          = 12,
  parameter int DW          = 8,
  parameter int BLK_LG      = 3,
  parameter int DOM_W       = 3,
  parameter int TRUSTED_DOM = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_instr,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic [DOM_W-1:0] cur_dom,
  input  logic [AW-1:0]    map_base,
  input  logic [AW-1:0]    stk_floor,
  input  logic [AW-1:0]    stk_bound,
  input  logic [DW-1:0]    ram_rdata,
  input  logic             fault_clr,
  output logic             stall,
  output logic [AW-1:0]    ram_addr,
  output logic             ram_we,
  output logic [DW-1:0]    ram_wdata,
  output logic             panic,
  output logic             fault_vld,
  output logic [AW-1:0]    fault_addr
);
  import sg_pkg::*;

  localparam int REC_W   = DOM_W + 1;
  localparam int REC_PER = DW / REC_W;
  localparam int SEL_W   = (REC_PER > 1) ? $clog2(REC_PER) : 1;

  sg_state_e        state_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [DOM_W-1:0] dom_q;
  logic [SEL_W-1:0] sel_q;
  logic             in_stk_q;
  logic             stk_ok_q;
  logic             ok_q;
  logic             panic_q;

  logic             need_chk;
  logic [AW-1:0]    map_addr;
  logic [SEL_W-1:0] rec_sel;
  logic             in_stack;
  logic             stack_ok;
  logic             own_match;
  logic             permit;

  assign need_chk = st_instr && cpu_we && (cur_dom != DOM_W'(TRUSTED_DOM));

  sg_locate #(
    .AW(AW), .BLK_LG(BLK_LG), .SEL_W(SEL_W)
  ) u_locate (
    .addr     (cpu_addr),
    .map_base (map_base),
    .stk_floor(stk_floor),
    .stk_bound(stk_bound),
    .map_addr (map_addr),
    .rec_sel  (rec_sel),
    .in_stack (in_stack),
    .stack_ok (stack_ok)
  );

  sg_owner_match #(
    .DW(DW), .DOM_W(DOM_W), .REC_W(REC_W), .SEL_W(SEL_W)
  ) u_match (
    .rdata  (ram_rdata),
    .rec_sel(sel_q),
    .dom    (dom_q),
    .match  (own_match)
  );

  assign permit = in_stk_q ? stk_ok_q : own_match;

  // RAM port ownership: the core in idle, the checker otherwise.
  always_comb begin
    ram_addr  = cpu_addr;
    ram_we    = cpu_we;
    ram_wdata = cpu_wdata;
    stall     = 1'b0;
    unique case (state_q)
      SG_IDLE: begin
        if (need_chk) begin
          ram_addr = map_addr;
          ram_we   = 1'b0;
          stall    = 1'b1;
        end
      end
      SG_LOOK: begin
        ram_addr  = addr_q;
        ram_we    = 1'b0;
        ram_wdata = data_q;
        stall     = 1'b1;
      end
      SG_COMMIT: begin
        ram_addr  = addr_q;
        ram_we    = ok_q;
        ram_wdata = data_q;
      end
      default: begin
        ram_we = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SG_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      dom_q    <= '0;
      sel_q    <= '0;
      in_stk_q <= 1'b0;
      stk_ok_q <= 1'b0;
      ok_q     <= 1'b0;
      panic_q  <= 1'b0;
    end else begin
      panic_q <= 1'b0;
      unique case (state_q)
        SG_IDLE: begin
          if (need_chk) begin
            addr_q   <= cpu_addr;
            data_q   <= cpu_wdata;
            dom_q    <= cur_dom;
            sel_q    <= rec_sel;
            in_stk_q <= in_stack;
            stk_ok_q <= stack_ok;
            state_q  <= SG_LOOK;
          end
        end
        SG_LOOK: begin
          ok_q    <= permit;
          panic_q <= !permit;
          state_q <= SG_COMMIT;
        end
        SG_COMMIT: begin
          ok_q    <= 1'b0;
          state_q <= SG_IDLE;
        end
        default: state_q <= SG_IDLE;
      endcase
    end
  end

  // First refused address is kept until software clears it.
  always_ff @(posedge clk) begin
    if (rst) begin
      fault_vld  <= 1'b0;
      fault_addr <= '0;
    end else if ((state_q == SG_LOOK) && !permit && (!fault_vld || fault_clr)) begin
      fault_vld  <= 1'b1;
      fault_addr <= addr_q;
    end else if (fault_clr) begin
      fault_vld <= 1'b0;
    end
  end

  assign panic = panic_q;
endmodule

// File: rtl/sg_chk.sv
module sg_chk #(
  parameter int AW          = 12,
  parameter int DOM_W       = 3,
  parameter int TRUSTED_DOM = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             st_instr,
  input logic             cpu_we,
  input logic [DOM_W-1:0] cur_dom,
  input logic             stall,
  input logic             ram_we,
  input logic             panic,
  input logic             fault_vld,
  input logic             fault_clr,
  input logic [AW-1:0]    fault_addr
);
  // R2
  stall_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> !ram_we);

  // R2
  stall_second_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |=> stall);

  // R2
  stall_release_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && $past(stall)) |=> !stall);

  // R6
  panic_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    panic |=> !panic);

  // R6
  panic_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    panic |-> !ram_we);

  // R7
  fault_set_chk: assert property (@(posedge clk) disable iff (rst)
    panic |=> fault_vld);

  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_vld && !fault_clr) |=> (fault_vld && $stable(fault_addr)));

  // R8 R9
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && (!st_instr || cur_dom == DOM_W'(TRUSTED_DOM)) && !$past(stall))
      |-> (!stall && ram_we));
endmodule

bind store_guard sg_chk #(
  .AW(AW), .DOM_W(DOM_W), .TRUSTED_DOM(TRUSTED_DOM)
) u_sg_chk (
  .clk       (clk),
  .rst       (rst),
  .st_instr  (st_instr),
  .cpu_we    (cpu_we),
  .cur_dom   (cur_dom),
  .stall     (stall),
  .ram_we    (ram_we),
  .panic     (panic),
  .fault_vld (fault_vld),
  .fault_clr (fault_clr),
  .fault_addr(fault_addr)
);

// File: tb/store_guard_bench.sv
module store_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] MAP_BASE  = 12'h100;
  localparam logic [11:0] STK_FLOOR = 12'hC00;

  logic        clk = 1'b0;
  logic        rst;
  logic        st_instr, cpu_we, fault_clr;
  logic [11:0] cpu_addr, map_base, stk_floor, stk_bound;
  logic [7:0]  cpu_wdata, ram_rdata;
  logic [2:0]  cur_dom;
  logic        stall, ram_we, panic, fault_vld;
  logic [11:0] ram_addr, fault_addr;
  logic [7:0]  ram_wdata;

  logic [7:0] mem [0:4095];
  int checks = 0;
  int errors = 0;
  logic        exp_fv = 1'b0;
  logic [11:0] exp_fa = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  store_guard u_store_guard (
    .clk(clk), .rst(rst), .st_instr(st_instr), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cur_dom(cur_dom),
    .map_base(map_base), .stk_floor(stk_floor), .stk_bound(stk_bound),
    .ram_rdata(ram_rdata), .fault_clr(fault_clr), .stall(stall),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .panic(panic), .fault_vld(fault_vld), .fault_addr(fault_addr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] map_ix(input logic [11:0] a);
    return MAP_BASE + 12'(a[11:4]);
  endfunction

  function automatic logic [2:0] owner_of(input logic [11:0] a);
    logic [7:0] b;
    b = mem[map_ix(a)];
    return a[3] ? b[7:5] : b[3:1];
  endfunction

  function automatic logic allowed(input logic [11:0] a, input logic [2:0] dom);
    if (dom == 3'd0) return 1'b1;
    if (a >= STK_FLOOR) return (a < stk_bound);
    return (owner_of(a) == dom);
  endfunction

  task automatic set_owner(input logic [11:0] a, input logic [2:0] dom, input logic sb);
    if (a[3]) mem[map_ix(a)][7:4] = {dom, sb};
    else      mem[map_ix(a)][3:0] = {dom, sb};
  endtask

  task automatic do_store(input string tag, input logic [11:0] a, input logic [7:0] d,
                          input logic [2:0] dom, input logic st);
    logic [7:0] old;
    logic exp_ok, checked;
    int cyc;
    old     = mem[a];
    exp_ok  = !st ? 1'b1 : allowed(a, dom);
    checked = st && (dom != 3'd0);
    @(negedge clk);
    st_instr = st; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d; cur_dom = dom;
    #1;
    if (checked) begin
      chk("R2", "stall in first cycle", stall, 1);
      chk("R2", "map byte address", ram_addr, map_ix(a));
      chk("R2", "no write while stalled", ram_we, 0);
    end else begin
      chk(tag, "no stall on bypass", stall, 0);
      chk(tag, "bypass write enable", ram_we, 1);
      chk(tag, "bypass address", ram_addr, a);
    end
    cyc = 1;
    while (stall && cyc < 10) begin
      @(negedge clk); #1;
      cyc++;
    end
    if (checked) begin
      chk("R2", "cycles per checked store", cyc, 3);
      chk(tag, "commit write enable", ram_we, exp_ok);
      chk("R6", "panic in third cycle", panic, !exp_ok);
    end
    @(negedge clk);
    st_instr = 1'b0; cpu_we = 1'b0;
    #1;
    chk("R6", "panic dropped", panic, 0);
    chk(tag, "ram content", mem[a], exp_ok ? d : old);
    if (!exp_ok && !exp_fv) begin
      exp_fv = 1'b1;
      exp_fa = a;
    end
    chk("R7", "fault valid", fault_vld, exp_fv);
    if (exp_fv) chk("R7", "fault address", fault_addr, exp_fa);
  endtask

  task automatic clear_fault();
    @(negedge clk); fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
    #1;
    exp_fv = 1'b0;
    chk("R7", "fault cleared", fault_vld, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20061020));
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    rst = 1'b1; st_instr = 1'b0; cpu_we = 1'b0; fault_clr = 1'b0;
    cpu_addr = '0; cpu_wdata = '0; cur_dom = '0;
    map_base = MAP_BASE; stk_floor = STK_FLOOR; stk_bound = 12'hD00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1
    chk("R1", "stall after reset", stall, 0);
    chk("R1", "panic after reset", panic, 0);
    chk("R1", "fault_vld after reset", fault_vld, 0);
    chk("R1", "ram_we after reset", ram_we, 0);

    // R3: two blocks sharing one map byte
    set_owner(12'h238, 3'd3, 1'b1);
    set_owner(12'h230, 3'd5, 1'b0);
    do_store("R3", 12'h23C, 8'hA5, 3'd3, 1'b1);
    do_store("R3", 12'h231, 8'h5A, 3'd5, 1'b1);
    do_store("R3", 12'h23F, 8'h11, 3'd5, 1'b1);
    // R7: second refusal must not overwrite the held address
    do_store("R7", 12'h232, 8'h22, 3'd3, 1'b1);
    clear_fault();
    // R3: start flag and offset irrelevant
    set_owner(12'h300, 3'd4, 1'b1);
    do_store("R3", 12'h307, 8'h77, 3'd4, 1'b1);
    // R4
    set_owner(12'h410, 3'd2, 1'b0);
    do_store("R4", 12'h412, 8'h3C, 3'd2, 1'b1);
    // R8
    do_store("R8", 12'h238, 8'hC3, 3'd0, 1'b1);
    // R9
    do_store("R9", 12'h230, 8'h99, 3'd2, 1'b0);
    // R5: stack region ignores the map, bound is exclusive
    stk_bound = 12'hD00;
    set_owner(12'hC80, 3'd6, 1'b0);
    do_store("R5", 12'hC80, 8'h44, 3'd1, 1'b1);
    do_store("R5", 12'hCFF, 8'h45, 3'd1, 1'b1);
    do_store("R5", 12'hD00, 8'h46, 3'd1, 1'b1);
    clear_fault();

    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      logic [2:0]  dom;
      logic        st;
      a   = 12'($urandom);
      dom = 3'($urandom);
      if ($urandom_range(0, 1) == 0 && a < STK_FLOOR) dom = owner_of(a);
      st  = ($urandom_range(0, 9) != 0);
      stk_bound = STK_FLOOR + 12'($urandom_range(0, 1023));
      do_store((a >= STK_FLOOR) ? "R5" : "R4", a, 8'($urandom), dom, st);
      if ($urandom_range(0, 7) == 0) clear_fault();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule